// File: doc/BRIEF.md
# Converter Fault and Startup Supervisor

This block is the supervisory controller of a switching LED converter. It takes the already-digitised outputs of the analog comparators as inputs: three supply levels, the output-sense window, the undervoltage level, a winding-short comparator with its per-cycle strobe, the CS2-open flag and over-temperature. From these it decides whether the power switch may run. It moves through power-on reset, a startup wait, normal running, a timed stop and a latched stop. Each fault has its own way of being qualified and its own way of being released.

The faults differ in how they act. Loss of supply, output overvoltage and thermal shutdown are filtered by cycle counters and lead to a timed stop. That stop releases on its own once its particular condition clears. An undervoltage on the output-sense pin stops the switch at once, and so does an open CS2 sense path. A winding short has to be seen on four consecutive switching strobes. All three of these lock the switch off, and only a collapse of the supply below its reset level clears them.

Top module: `cvtr_supervisor`

## Requirements
- R1: From startup (code 1), switching begins on the next clock only when `vccAboveOn` is 1, `ovpUnderUv` is 0 and `overTemp` is 0. Otherwise the block stays in startup.
- R2: While running, `vccAboveOff` held at 0 for `LOWV_CYC` clocks leads to the timed stop (code 3) on the following clock. Release goes through startup and needs `vccAboveOn` at 1.
- R3: While running, `PULSE_LIMIT` consecutive `cs1Strobe` cycles with `cs1OverShort` at 1 lock the block (code 4) one clock after the last strobe. Cycles without a strobe are not counted. Only `vccAboveRst` at 0 leaves the locked state.
- R4: A strobe with `cs1OverShort` at 0 restarts the consecutive-pulse count.
- R5: While running, `cs2Open` at 1 locks the block on the next clock.
- R6: While running, `ovpOverUpper` held at 1 for `OVP_CYC` clocks leads to the timed stop. Release needs `ovpUnderLower` and `vccAboveOn` both at 1.
- R7: While running, `ovpUnderUv` at 1 locks the block on the next clock.
- R8: While running, `overTemp` held at 1 for `HOT_CYC` clocks leads to the timed stop. Release needs `vccAboveOn` at 1 and `overTemp` at 0.
- R9: `vccAboveRst` at 0 sends every state to power-on reset (code 0) on the next clock. From there the block goes to startup once `vccAboveRst` returns. Asynchronous reset also gives code 0.
- R10: `stateCode` is 0 for reset, 1 for startup, 2 for running, 3 for timed stop and 4 for locked. `swEnable` is 1 only in running, and `faultLatched` is 1 only in locked.
- R11: A filtered fault condition that drops for even one clock restarts its qualification count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| vccAboveOn | input | 1 | Supply above turn-on level |
| vccAboveOff | input | 1 | Supply above turn-off level |
| vccAboveRst | input | 1 | Supply above logic-reset level |
| ovpOverUpper | input | 1 | Output sense above upper overvoltage threshold |
| ovpUnderLower | input | 1 | Output sense below lower overvoltage threshold |
| ovpUnderUv | input | 1 | Output sense below undervoltage level |
| cs1Strobe | input | 1 | One-clock strobe per switching pulse |
| cs1OverShort | input | 1 | Inductor sense above winding-short level |
| cs2Open | input | 1 | Current sense 2 open |
| overTemp | input | 1 | Junction over-temperature |
| swEnable | output | 1 | Power switch may operate |
| faultLatched | output | 1 | Locked-off fault present |
| stateCode | output | 3 | Supervisor state code |

## Verification
The startup gate is tried with each blocking input set alone, which shows that every one of the three conditions holds the block in startup by itself. Each filtered fault is held for exactly its limit and then one clock longer, so an off-by-one in a counter is caught. A single-clock dropout of the low-supply condition shows that qualification restarts instead of accumulating. Each release rule is offered its partial condition first, which separates the two-term releases from the single-term ones. The winding-short sequence uses a broken run of over-threshold strobes and an unstrobed over-threshold level, which separates consecutive counting from plain totals and from level sensing.

// File: rtl/cvtr_sup_pkg.sv
package cvtr_sup_pkg;

  typedef enum logic [2:0] {
    ST_POR   = 3'd0,
    ST_START = 3'd1,
    ST_RUN   = 3'd2,
    ST_HOLD  = 3'd3,
    ST_LOCK  = 3'd4
  } supState_t;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_LOWV = 2'd1,
    CAUSE_OVP  = 2'd2,
    CAUSE_HOT  = 2'd3
  } stopCause_t;

  // control -> datapath
  typedef struct packed {
    logic armFilters;
    logic armShort;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic lowvHit;
    logic ovpHit;
    logic hotHit;
    logic shortHit;
  } dpFlags_t;

  localparam int NUM_FILT = 3;
  localparam int IDX_LOWV = 0;
  localparam int IDX_OVP  = 1;
  localparam int IDX_HOT  = 2;

endpackage

// File: rtl/cvtr_sup_dp.sv
module cvtr_sup_dp
  import cvtr_sup_pkg::*;
#(
  parameter int LOWV_CYC    = 100000,
  parameter int OVP_CYC     = 330000,
  parameter int HOT_CYC     = 100000,
  parameter int PULSE_LIMIT = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [NUM_FILT-1:0] filtCond,
  input  logic                cs1Strobe,
  input  logic                cs1OverShort,
  output dpFlags_t            flags
);

  localparam int MAX_AB  = (LOWV_CYC > OVP_CYC) ? LOWV_CYC : OVP_CYC;
  localparam int MAX_LIM = (MAX_AB > HOT_CYC) ? MAX_AB : HOT_CYC;
  localparam int CW      = $clog2(MAX_LIM + 1);
  localparam int SW      = $clog2(PULSE_LIMIT + 1);
  localparam int LIMS [NUM_FILT] = '{LOWV_CYC, OVP_CYC, HOT_CYC};

  logic [NUM_FILT-1:0] filtHit;

  // One saturating qualification counter per filtered fault
  for (genvar g = 0; g < NUM_FILT; g++) begin : g_filt
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cnt <= '0;
      else if (!strobe.armFilters || !filtCond[g])
        cnt <= '0;
      else if (cnt != CW'(LIMS[g]))
        cnt <= cnt + CW'(1);
    end

    assign filtHit[g] = (cnt == CW'(LIMS[g]));

    p_filt_bound_r11: assert property (@(posedge clk) disable iff (!rstN)
      cnt <= CW'(LIMS[g]));
    p_filt_restart_r11: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.armFilters && !filtCond[g]) |=> (cnt == '0));
  end

  // Consecutive winding-short pulse counter
  logic [SW-1:0] shortCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      shortCnt <= '0;
    else if (!strobe.armShort)
      shortCnt <= '0;
    else if (cs1Strobe) begin
      if (!cs1OverShort)
        shortCnt <= '0;
      else if (shortCnt != SW'(PULSE_LIMIT))
        shortCnt <= shortCnt + SW'(1);
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    shortCnt <= SW'(PULSE_LIMIT));
  p_short_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.armShort && cs1Strobe && !cs1OverShort) |=> (shortCnt == '0));
  p_short_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.armShort && !cs1Strobe) |=> $stable(shortCnt));

  assign flags.lowvHit  = filtHit[IDX_LOWV];
  assign flags.ovpHit   = filtHit[IDX_OVP];
  assign flags.hotHit   = filtHit[IDX_HOT];
  assign flags.shortHit = (shortCnt == SW'(PULSE_LIMIT));

endmodule

// File: rtl/cvtr_sup_ctrl.sv
module cvtr_sup_ctrl
  import cvtr_sup_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        vccAboveOn,
  input  logic        vccAboveRst,
  input  logic        ovpUnderLower,
  input  logic        ovpUnderUv,
  input  logic        cs2Open,
  input  logic        overTemp,
  input  dpFlags_t    flags,
  output supState_t   state,
  output ctrlStrobe_t strobe
);

  supState_t  stateNxt;
  stopCause_t cause, causeNxt;
  logic       startOk;
  logic       releaseOk;

  assign startOk = vccAboveOn && !ovpUnderUv && !overTemp;

  always_comb begin
    unique case (cause)
      CAUSE_LOWV: releaseOk = vccAboveOn;
      CAUSE_OVP:  releaseOk = vccAboveOn && ovpUnderLower;
      CAUSE_HOT:  releaseOk = vccAboveOn && !overTemp;
      default:    releaseOk = vccAboveOn;
    endcase
  end

  always_comb begin
    stateNxt = state;
    causeNxt = cause;
    unique case (state)
      ST_POR:   stateNxt = ST_START;
      ST_START: if (startOk) stateNxt = ST_RUN;
      ST_RUN: begin
        if (ovpUnderUv || cs2Open || flags.shortHit) begin
          stateNxt = ST_LOCK;
        end else if (flags.lowvHit) begin
          stateNxt = ST_HOLD;
          causeNxt = CAUSE_LOWV;
        end else if (flags.ovpHit) begin
          stateNxt = ST_HOLD;
          causeNxt = CAUSE_OVP;
        end else if (flags.hotHit) begin
          stateNxt = ST_HOLD;
          causeNxt = CAUSE_HOT;
        end
      end
      ST_HOLD: if (releaseOk) stateNxt = ST_START;
      ST_LOCK: stateNxt = ST_LOCK;
      default: stateNxt = ST_POR;
    endcase
    if (!vccAboveRst) begin
      stateNxt = ST_POR;
      causeNxt = CAUSE_NONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_POR;
      cause <= CAUSE_NONE;
    end else begin
      state <= stateNxt;
      cause <= causeNxt;
    end
  end

  assign strobe.armFilters = (state == ST_RUN);
  assign strobe.armShort   = (state == ST_RUN);

  p_start_gate_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && $past(state) == ST_START)
      |-> $past(vccAboveOn && !ovpUnderUv && !overTemp));
  p_por_return_r9: assert property (@(posedge clk) disable iff (!rstN)
    !vccAboveRst |=> (state == ST_POR));
  p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOCK && vccAboveRst) |=> (state == ST_LOCK));
  p_uv_lock_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && vccAboveRst && ovpUnderUv) |=> (state == ST_LOCK));
  p_cs2_lock_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && vccAboveRst && cs2Open) |=> (state == ST_LOCK));
  p_ovp_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && cause == CAUSE_OVP && vccAboveRst
      && !(ovpUnderLower && vccAboveOn)) |=> (state == ST_HOLD));
  p_hot_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && cause == CAUSE_HOT && vccAboveRst && overTemp)
      |=> (state == ST_HOLD));

endmodule

// File: rtl/cvtr_supervisor.sv
module cvtr_supervisor
  import cvtr_sup_pkg::*;
#(
  parameter int LOWV_CYC    = 100000,
  parameter int OVP_CYC     = 330000,
  parameter int HOT_CYC     = 100000,
  parameter int PULSE_LIMIT = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       vccAboveOn,
  input  logic       vccAboveOff,
  input  logic       vccAboveRst,
  input  logic       ovpOverUpper,
  input  logic       ovpUnderLower,
  input  logic       ovpUnderUv,
  input  logic       cs1Strobe,
  input  logic       cs1OverShort,
  input  logic       cs2Open,
  input  logic       overTemp,
  output logic       swEnable,
  output logic       faultLatched,
  output logic [2:0] stateCode
);

  supState_t           state;
  ctrlStrobe_t         strobe;
  dpFlags_t            flags;
  logic [NUM_FILT-1:0] filtCond;

  assign filtCond[IDX_LOWV] = !vccAboveOff;
  assign filtCond[IDX_OVP]  = ovpOverUpper;
  assign filtCond[IDX_HOT]  = overTemp;

  cvtr_sup_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .vccAboveOn   (vccAboveOn),
    .vccAboveRst  (vccAboveRst),
    .ovpUnderLower(ovpUnderLower),
    .ovpUnderUv   (ovpUnderUv),
    .cs2Open      (cs2Open),
    .overTemp     (overTemp),
    .flags        (flags),
    .state        (state),
    .strobe       (strobe)
  );

  cvtr_sup_dp #(
    .LOWV_CYC   (LOWV_CYC),
    .OVP_CYC    (OVP_CYC),
    .HOT_CYC    (HOT_CYC),
    .PULSE_LIMIT(PULSE_LIMIT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .filtCond    (filtCond),
    .cs1Strobe   (cs1Strobe),
    .cs1OverShort(cs1OverShort),
    .flags       (flags)
  );

  assign swEnable     = (state == ST_RUN);
  assign faultLatched = (state == ST_LOCK);
  assign stateCode    = state;

  p_excl_out_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(swEnable && faultLatched));

endmodule

// File: tb/sim_cvtr_supervisor.sv
module sim_cvtr_supervisor;

  localparam int LOWV = 6;
  localparam int OVPC = 10;
  localparam int HOTC = 8;
  localparam int NPUL = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vccAboveOn = 0, vccAboveOff = 0, vccAboveRst = 0;
  logic ovpOverUpper = 0, ovpUnderLower = 0, ovpUnderUv = 0;
  logic cs1Strobe = 0, cs1OverShort = 0, cs2Open = 0, overTemp = 0;
  logic swEnable, faultLatched;
  logic [2:0] stateCode;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  cvtr_supervisor #(
    .LOWV_CYC(LOWV), .OVP_CYC(OVPC), .HOT_CYC(HOTC), .PULSE_LIMIT(NPUL)
  ) u0 (
    .clk(clk), .rstN(rstN),
    .vccAboveOn(vccAboveOn), .vccAboveOff(vccAboveOff), .vccAboveRst(vccAboveRst),
    .ovpOverUpper(ovpOverUpper), .ovpUnderLower(ovpUnderLower), .ovpUnderUv(ovpUnderUv),
    .cs1Strobe(cs1Strobe), .cs1OverShort(cs1OverShort), .cs2Open(cs2Open),
    .overTemp(overTemp),
    .swEnable(swEnable), .faultLatched(faultLatched), .stateCode(stateCode)
  );

  // {req[3:0], inputs[7:0], hold[7:0], code[2:0]}
  // inputs = {vccAboveOn, vccAboveOff, vccAboveRst, ovpOverUpper,
  //           ovpUnderLower, ovpUnderUv, cs2Open, overTemp}
  localparam int NV = 33;
  localparam logic [22:0] VEC [NV] = '{
    {4'd9,  8'h00, 8'd3,  3'd0},  // R9 supply below reset level
    {4'd1,  8'h28, 8'd2,  3'd1},  // R1 into startup, no turn-on
    {4'd1,  8'hEC, 8'd3,  3'd1},  // R1 blocked by undervoltage
    {4'd1,  8'hE9, 8'd3,  3'd1},  // R1 blocked by over-temperature
    {4'd1,  8'hE8, 8'd1,  3'd2},  // R1 starts
    {4'd11, 8'h28, 8'd5,  3'd2},  // R11 low supply, not yet qualified
    {4'd11, 8'h68, 8'd1,  3'd2},  // R11 one-clock dropout
    {4'd2,  8'h28, 8'd6,  3'd2},  // R2 exactly the limit
    {4'd2,  8'h28, 8'd1,  3'd3},  // R2 timed stop
    {4'd2,  8'h68, 8'd3,  3'd3},  // R2 no turn-on yet
    {4'd2,  8'hE8, 8'd1,  3'd1},  // R2 release to startup
    {4'd2,  8'hE8, 8'd1,  3'd2},  // R2 running again
    {4'd6,  8'hF0, 8'd10, 3'd2},  // R6 overvoltage at limit
    {4'd6,  8'hF0, 8'd1,  3'd3},  // R6 timed stop
    {4'd6,  8'hE0, 8'd3,  3'd3},  // R6 inside hysteresis window
    {4'd6,  8'h68, 8'd3,  3'd3},  // R6 below lower, supply not on
    {4'd6,  8'hE8, 8'd1,  3'd1},  // R6 release
    {4'd6,  8'hE8, 8'd1,  3'd2},  // R6 running
    {4'd8,  8'hE9, 8'd8,  3'd2},  // R8 hot at limit
    {4'd8,  8'hE9, 8'd1,  3'd3},  // R8 timed stop
    {4'd8,  8'hE9, 8'd3,  3'd3},  // R8 still hot
    {4'd8,  8'h68, 8'd2,  3'd3},  // R8 cool, supply not on
    {4'd8,  8'hE8, 8'd1,  3'd1},  // R8 release
    {4'd8,  8'hE8, 8'd1,  3'd2},  // R8 running
    {4'd7,  8'hEC, 8'd1,  3'd4},  // R7 immediate lock
    {4'd7,  8'hE8, 8'd4,  3'd4},  // R7 stays locked
    {4'd9,  8'h00, 8'd1,  3'd0},  // R9 supply reset clears lock
    {4'd9,  8'hE8, 8'd1,  3'd1},  // R9 startup after reset
    {4'd9,  8'hE8, 8'd1,  3'd2},  // R9 running
    {4'd5,  8'hEA, 8'd1,  3'd4},  // R5 CS2 open locks
    {4'd5,  8'hE8, 8'd3,  3'd4},  // R5 stays locked
    {4'd9,  8'h08, 8'd1,  3'd0},  // R9 reset from locked
    {4'd5,  8'hE8, 8'd2,  3'd2}   // R5 back to running
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chkState(input string tag, input int exp);
    chk(tag, stateCode, exp);
    chk({tag, " R10 swEnable"}, swEnable, (exp == 2) ? 1 : 0);
    chk({tag, " R10 faultLatched"}, faultLatched, (exp == 4) ? 1 : 0);
  endtask

  task automatic applyIn(input logic [7:0] v);
    {vccAboveOn, vccAboveOff, vccAboveRst, ovpOverUpper,
     ovpUnderLower, ovpUnderUv, cs2Open, overTemp} = v;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input logic over);
    cs1Strobe = 1'b1;
    cs1OverShort = over;
    @(negedge clk);
    cs1Strobe = 1'b0;
    cs1OverShort = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chkState("R9 in reset", 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      applyIn(VEC[i][18:11]);
      waitCyc(int'(VEC[i][10:3]));
      chkState($sformatf("R%0d vec%0d", VEC[i][22:19], i), int'(VEC[i][2:0]));
    end

    // R3: an over-threshold level without strobes is not counted
    cs1OverShort = 1'b1;
    waitCyc(10);
    cs1OverShort = 1'b0;
    chkState("R3 no strobe", 2);

    // R4: a broken run does not accumulate
    pulse(1'b1); pulse(1'b1); pulse(1'b1);
    pulse(1'b0);
    pulse(1'b1); pulse(1'b1); pulse(1'b1);
    chkState("R4 broken run", 2);

    // R3: fourth consecutive pulse, lock one clock later
    pulse(1'b1);
    chkState("R3 at limit", 2);
    waitCyc(1);
    chkState("R3 locked", 4);
    waitCyc(5);
    chkState("R3 held", 4);
    applyIn(8'h00);
    waitCyc(1);
    chkState("R3 R9 cleared", 0);
    applyIn(8'hE8);
    waitCyc(2);
    chkState("R3 restarted", 2);

    // R9: asynchronous reset while running
    rstN = 1'b0;
    #1;
    chk("R9 async reset", stateCode, 0);
    @(negedge clk);
    rstN = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule